// File: doc/BRIEF.md
# Interrupt Response Cycle Sequencer

This block steps through the machine cycles a processor core runs after it accepts an interrupt. One clock is one T-state. A non-maskable request, or an enabled maskable request, is accepted only while the block is idle. The block then presents one machine cycle at a time: the cycle type, the cycle length in T-states, a marker on the first and on the last T-state, and a strobe on each clock where the stack pointer must be decremented. When the sequence ends, `done` pulses for one clock.

The maskable response depends on a 2-bit mode select. Modes 0 and 3 both run the mode-0 response. In mode 0, a flag tells whether the device supplies a three-byte call or a one-byte restart. Mode 1 is a fixed restart. Mode 2 adds a two-byte read from the vector table after the return address has been pushed. The sequencer only orders and times the cycles. Address generation, data capture and bus strobes belong to the neighbouring datapath.

States: `ST_IDLE`, `ST_NMI_FETCH`, `ST_INTA`, `ST_OPND_LO`, `ST_OPND_HI`, `ST_PUSH_HI`, `ST_PUSH_LO`, `ST_VEC_LO`, `ST_VEC_HI`, `ST_DONE`.

Transitions:
- `ST_IDLE` moves to `ST_NMI_FETCH` when a non-maskable request is accepted, or to `ST_INTA` when a maskable one is accepted.
- `ST_NMI_FETCH` moves to `ST_PUSH_HI`.
- `ST_INTA` moves to `ST_OPND_LO` for a mode-0 call, and to `ST_PUSH_HI` otherwise.
- `ST_OPND_LO` moves to `ST_OPND_HI`, and `ST_OPND_HI` moves to `ST_PUSH_HI`.
- `ST_PUSH_HI` moves to `ST_PUSH_LO`.
- `ST_PUSH_LO` moves to `ST_VEC_LO` in mode 2, and to `ST_DONE` otherwise.
- `ST_VEC_LO` moves to `ST_VEC_HI`, and `ST_VEC_HI` moves to `ST_DONE`.
- `ST_DONE` moves to `ST_IDLE`.

Every transition out of a cycle state happens on that cycle's last T-state. The transition from `ST_DONE` to `ST_IDLE` is unconditional.

Top module: `irq_resp_seq`

## Requirements
- R1: While reset is held and after it is released with no request present: `busy`=0, `done`=0, `cyc_type`=0, `cyc_tlen`=0, `sp_dec`=0.
- R2: Cycle-type codes on `cyc_type` are: 0 none, 1 discarded opcode fetch, 2 interrupt acknowledge, 3 operand low read, 4 operand high read, 5 stack write high, 6 stack write low, 7 vector low read, 8 vector high read. A non-maskable response is a fetch (5 T), then a stack write high (3 T), then a stack write low (3 T). Its first T-state appears on the clock after the edge that samples the request.
- R3: When both request kinds are present in the same idle clock, the non-maskable sequence runs.
- R4: A maskable request with `int_en`=0 starts nothing.
- R5: Mode 0 with `m0_is_call`=1 runs the following cycles in order:
  - acknowledge, 6 T
  - operand low read, 3 T
  - operand high read, 4 T
  - stack write high, 3 T
  - stack write low, 3 T
- R6: Mode 0 with `m0_is_call`=0 runs an acknowledge cycle (6 T), then stack write high (3 T), then stack write low (3 T).
- R7: Mode select 3 gives exactly the mode-0 sequences.
- R8: Mode 1 runs an acknowledge cycle (7 T), then stack write high (3 T), then stack write low (3 T).
- R9: Mode 2 runs the following cycles in order:
  - acknowledge, 7 T
  - stack write high, 3 T
  - stack write low, 3 T
  - vector low read, 3 T
  - vector high read, 3 T
- R10: `sp_dec` is high for exactly the first T-state of each stack-write cycle and is low on every other clock. Each response therefore gives two decrements, and each one comes before the write it serves.
- R11: `done` is high for the single clock that follows the final T-state of the last cycle. On that clock `cyc_type`=0. On the next clock `busy`=0.
- R12: Requests that arrive while `busy`=1 are ignored: no second response follows the current one.
- R13: Within a cycle, `cyc_type` and `cyc_tlen` stay stable. `cyc_first` is high only on the cycle's first T-state and `t_last` only on its last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per period |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable interrupt request |
| int_req | input | 1 | Maskable interrupt request |
| int_en | input | 1 | Maskable interrupt enable |
| int_mode | input | 2 | Maskable response mode (3 acts as 0) |
| m0_is_call | input | 1 | Mode 0: device supplies a three-byte call (1) or a restart (0) |
| cyc_type | output | 4 | Current machine-cycle type, codes in R2 |
| cyc_tlen | output | 3 | T-state count of the current cycle |
| cyc_first | output | 1 | First T-state of a cycle |
| t_last | output | 1 | Last T-state of a cycle |
| sp_dec | output | 1 | Decrement the stack pointer this clock |
| busy | output | 1 | Response in progress |
| done | output | 1 | One-clock pulse after the final T-state |

## Verification
The assertions take for granted that request levels are settled at the clock edge. They also assume that `int_mode` and `m0_is_call` are valid on the idle clock in which a request is sampled, because both values are captured at acceptance. The stimulus changes inputs only at falling edges and holds each request for exactly one idle clock before clearing it. The one exception is the busy-window test, which raises requests deliberately in the middle of a response to show that they are dropped.

// File: rtl/irq_resp_pkg.sv
package irq_resp_pkg;

    typedef enum logic [3:0] {
        CYC_NONE      = 4'd0,
        CYC_NMI_FETCH = 4'd1,
        CYC_INTA      = 4'd2,
        CYC_OPND_LO   = 4'd3,
        CYC_OPND_HI   = 4'd4,
        CYC_PUSH_HI   = 4'd5,
        CYC_PUSH_LO   = 4'd6,
        CYC_VEC_LO    = 4'd7,
        CYC_VEC_HI    = 4'd8
    } cyc_e;

    typedef enum logic [2:0] {
        K_NMI,
        K_M0_CALL,
        K_M0_RST,
        K_M1,
        K_M2
    } kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_NMI_FETCH,
        ST_INTA,
        ST_OPND_LO,
        ST_OPND_HI,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_DONE
    } st_e;

endpackage

// File: rtl/irq_resp_arb.sv
module irq_resp_arb
    import irq_resp_pkg::*;
(
    input  logic       nmi_req,
    input  logic       int_req,
    input  logic       int_en,
    input  logic [1:0] int_mode,
    input  logic       m0_is_call,
    output logic       accept,
    output kind_e      kind
);

    assign accept = nmi_req | (int_req & int_en);

    always_comb begin
        if (nmi_req) begin
            kind = K_NMI;
        end else begin
            unique case (int_mode)
                2'd1:    kind = K_M1;
                2'd2:    kind = K_M2;
                default: kind = m0_is_call ? K_M0_CALL : K_M0_RST;
            endcase
        end
    end

endmodule

// File: rtl/irq_tstate_ctr.sv
module irq_tstate_ctr #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [TW-1:0] len,
    output logic          first,
    output logic          last
);

    logic [TW-1:0] cnt_q;

    assign first = en && (cnt_q == '0);
    assign last  = en && (cnt_q == len - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n || !en || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R13
    tcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt_q < len));

endmodule

// File: rtl/irq_resp_seq.sv
module irq_resp_seq
    import irq_resp_pkg::*;
#(
    parameter int TW         = 3,
    parameter int T_NMI_FTCH = 5,
    parameter int T_ACK_M0   = 6,
    parameter int T_ACK_M12  = 7,
    parameter int T_MEM      = 3,
    parameter int T_OPND_HI  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nmi_req,
    input  logic          int_req,
    input  logic          int_en,
    input  logic [1:0]    int_mode,
    input  logic          m0_is_call,
    output logic [3:0]    cyc_type,
    output logic [TW-1:0] cyc_tlen,
    output logic          cyc_first,
    output logic          t_last,
    output logic          sp_dec,
    output logic          busy,
    output logic          done
);

    localparam logic [TW-1:0] L_NMI = TW'(T_NMI_FTCH);
    localparam logic [TW-1:0] L_A0  = TW'(T_ACK_M0);
    localparam logic [TW-1:0] L_A12 = TW'(T_ACK_M12);
    localparam logic [TW-1:0] L_MEM = TW'(T_MEM);
    localparam logic [TW-1:0] L_OPH = TW'(T_OPND_HI);

    st_e   state_q, state_d;
    kind_e kind_q, kind_w;
    logic  accept_w;
    logic  tmr_en, first_w, last_w;
    cyc_e  cyc_w;

    irq_resp_arb u_arb (
        .nmi_req    (nmi_req),
        .int_req    (int_req),
        .int_en     (int_en),
        .int_mode   (int_mode),
        .m0_is_call (m0_is_call),
        .accept     (accept_w),
        .kind       (kind_w)
    );

    irq_tstate_ctr #(.TW(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tmr_en),
        .len   (cyc_tlen),
        .first (first_w),
        .last  (last_w)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= K_NMI;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && accept_w) begin
                kind_q <= kind_w;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (accept_w) state_d = (kind_w == K_NMI) ? ST_NMI_FETCH : ST_INTA;
            ST_NMI_FETCH:
                if (last_w) state_d = ST_PUSH_HI;
            ST_INTA:
                if (last_w) state_d = (kind_q == K_M0_CALL) ? ST_OPND_LO : ST_PUSH_HI;
            ST_OPND_LO:
                if (last_w) state_d = ST_OPND_HI;
            ST_OPND_HI:
                if (last_w) state_d = ST_PUSH_HI;
            ST_PUSH_HI:
                if (last_w) state_d = ST_PUSH_LO;
            ST_PUSH_LO:
                if (last_w) state_d = (kind_q == K_M2) ? ST_VEC_LO : ST_DONE;
            ST_VEC_LO:
                if (last_w) state_d = ST_VEC_HI;
            ST_VEC_HI:
                if (last_w) state_d = ST_DONE;
            ST_DONE:
                state_d = ST_IDLE;
            default:
                state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cyc_w    = CYC_NONE;
        cyc_tlen = '0;
        unique case (state_q)
            ST_NMI_FETCH: begin cyc_w = CYC_NMI_FETCH; cyc_tlen = L_NMI; end
            ST_INTA: begin
                cyc_w    = CYC_INTA;
                cyc_tlen = (kind_q == K_M1 || kind_q == K_M2) ? L_A12 : L_A0;
            end
            ST_OPND_LO: begin cyc_w = CYC_OPND_LO; cyc_tlen = L_MEM; end
            ST_OPND_HI: begin cyc_w = CYC_OPND_HI; cyc_tlen = L_OPH; end
            ST_PUSH_HI: begin cyc_w = CYC_PUSH_HI; cyc_tlen = L_MEM; end
            ST_PUSH_LO: begin cyc_w = CYC_PUSH_LO; cyc_tlen = L_MEM; end
            ST_VEC_LO:  begin cyc_w = CYC_VEC_LO;  cyc_tlen = L_MEM; end
            ST_VEC_HI:  begin cyc_w = CYC_VEC_HI;  cyc_tlen = L_MEM; end
            default:    begin cyc_w = CYC_NONE;    cyc_tlen = '0;    end
        endcase
    end

    assign tmr_en    = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign cyc_type  = cyc_w;
    assign cyc_first = first_w;
    assign t_last    = last_w;
    assign sp_dec    = first_w && (state_q == ST_PUSH_HI || state_q == ST_PUSH_LO);
    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_DONE);

    // R11
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(t_last));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R13
    type_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_en && !t_last) |=> ($stable(cyc_type) && $stable(cyc_tlen)));

    // R10
    push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_first && cyc_type == CYC_PUSH_LO) |-> $past(cyc_type) == CYC_PUSH_HI);

    // R9
    vec_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_first && cyc_type == CYC_VEC_LO) |-> $past(cyc_type) == CYC_PUSH_LO);

    // R12
    kind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(kind_q));

endmodule

// File: tb/sim_irq_resp_seq.sv
`timescale 1ns/1ps
module sim_irq_resp_seq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       nmi_req, int_req, int_en, m0_is_call;
    logic [1:0] int_mode;
    logic [3:0] cyc_type;
    logic [2:0] cyc_tlen;
    logic       cyc_first, t_last, sp_dec, busy, done;

    int vecs = 0;
    int errs = 0;
    int exp_typ [0:5];
    int exp_len [0:5];
    int exp_n;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    irq_resp_seq u0 (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .int_req(int_req),
        .int_en(int_en), .int_mode(int_mode), .m0_is_call(m0_is_call),
        .cyc_type(cyc_type), .cyc_tlen(cyc_tlen), .cyc_first(cyc_first),
        .t_last(t_last), .sp_dec(sp_dec), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fire(input logic n, input logic i, input logic e,
                        input logic [1:0] m, input logic c);
        @(negedge clk);
        nmi_req = n; int_req = i; int_en = e; int_mode = m; m0_is_call = c;
        @(negedge clk);
        nmi_req = 0; int_req = 0; int_en = 0; int_mode = 0; m0_is_call = 0;
    endtask

    task automatic run_resp(input string req);
        for (int i = 0; i < exp_n; i++) begin
            for (int t = 0; t < exp_len[i]; t++) begin
                chk(req, int'(cyc_type), exp_typ[i]);
                chk({req, "/R13 tlen"}, int'(cyc_tlen), exp_len[i]);
                chk({req, "/R13 first"}, int'(cyc_first), int'(t == 0));
                chk({req, "/R13 last"}, int'(t_last), int'(t == exp_len[i] - 1));
                chk({req, "/R10 sp_dec"}, int'(sp_dec),
                    int'(t == 0 && (exp_typ[i] == 5 || exp_typ[i] == 6)));
                chk({req, " busy"}, int'(busy), 1);
                @(negedge clk);
            end
        end
        chk({req, "/R11 done"}, int'(done), 1);
        chk({req, "/R11 type"}, int'(cyc_type), 0);
        @(negedge clk);
        chk({req, "/R11 done off"}, int'(done), 0);
        chk({req, "/R11 idle"}, int'(busy), 0);
    endtask

    task automatic set_nmi;
        exp_n = 3;
        exp_typ[0] = 1; exp_len[0] = 5;
        exp_typ[1] = 5; exp_len[1] = 3;
        exp_typ[2] = 6; exp_len[2] = 3;
    endtask

    task automatic set_ack_push(input int ack_len);
        exp_n = 3;
        exp_typ[0] = 2; exp_len[0] = ack_len;
        exp_typ[1] = 5; exp_len[1] = 3;
        exp_typ[2] = 6; exp_len[2] = 3;
    endtask

    task automatic set_m0_call;
        exp_n = 5;
        exp_typ[0] = 2; exp_len[0] = 6;
        exp_typ[1] = 3; exp_len[1] = 3;
        exp_typ[2] = 4; exp_len[2] = 4;
        exp_typ[3] = 5; exp_len[3] = 3;
        exp_typ[4] = 6; exp_len[4] = 3;
    endtask

    task automatic t_reset;
        rst_n = 0;
        nmi_req = 0; int_req = 0; int_en = 0; int_mode = 0; m0_is_call = 0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", int'(busy), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 type", int'(cyc_type), 0);
        chk("R1 tlen", int'(cyc_tlen), 0);
        chk("R1 sp_dec", int'(sp_dec), 0);
    endtask

    task automatic t_nmi;
        set_nmi();
        fire(1, 0, 0, 0, 0);
        run_resp("R2 nmi");
    endtask

    task automatic t_prio;
        set_nmi();
        fire(1, 1, 1, 2, 0);
        run_resp("R3 prio");
    endtask

    task automatic t_masked;
        @(negedge clk);
        int_req = 1; int_en = 0; int_mode = 1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R4 masked busy", int'(busy), 0);
            chk("R4 masked type", int'(cyc_type), 0);
        end
        int_req = 0; int_mode = 0;
    endtask

    task automatic t_m0_call;
        set_m0_call();
        fire(0, 1, 1, 0, 1);
        run_resp("R5 m0 call");
    endtask

    task automatic t_m0_rst;
        set_ack_push(6);
        fire(0, 1, 1, 0, 0);
        run_resp("R6 m0 rst");
    endtask

    task automatic t_m3;
        set_m0_call();
        fire(0, 1, 1, 3, 1);
        run_resp("R7 m3 call");
        set_ack_push(6);
        fire(0, 1, 1, 3, 0);
        run_resp("R7 m3 rst");
    endtask

    task automatic t_m1;
        set_ack_push(7);
        fire(0, 1, 1, 1, 0);
        run_resp("R8 m1");
    endtask

    task automatic t_m2;
        exp_n = 5;
        exp_typ[0] = 2; exp_len[0] = 7;
        exp_typ[1] = 5; exp_len[1] = 3;
        exp_typ[2] = 6; exp_len[2] = 3;
        exp_typ[3] = 7; exp_len[3] = 3;
        exp_typ[4] = 8; exp_len[4] = 3;
        fire(0, 1, 1, 2, 1);
        run_resp("R9 m2");
    endtask

    task automatic t_busy_ignore;
        fire(1, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        nmi_req = 1; int_req = 1; int_en = 1; int_mode = 1;
        repeat (2) @(negedge clk);
        nmi_req = 0; int_req = 0; int_en = 0; int_mode = 0;
        repeat (7) @(negedge clk);
        chk("R12 done reached", int'(done), 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R12 no restart busy", int'(busy), 0);
            chk("R12 no restart type", int'(cyc_type), 0);
        end
    endtask

    initial begin
        t_reset();
        t_nmi();
        t_prio();
        t_masked();
        t_m0_call();
        t_m0_rst();
        t_m3();
        t_m1();
        t_m2();
        t_busy_ignore();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            vecs++;
            errs++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule